// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal clocked bus and an external asynchronous static RAM of 2^18 words by 16 bits. The internal side presents one word request at a time through a valid/ready handshake: an address, write data, a per-byte lane mask and a read/write flag. The controller latches the request and plays out a cycle on the memory's active-low strobes (chip select, output enable, write strobe and one enable per byte lane). For a read it returns the word with a one-cycle valid pulse.

Every phase length is a whole number of clock cycles set by a parameter. At elaboration the block checks each length against the memory's nanosecond minimums at the configured clock period. The shared data bus is split into a drive value, a drive enable and an input sample. The controller asserts its drive enable only during the three write phases, and it always holds output enable high while driving. A write that follows a read waits in a turnaround phase before driving.

States: `ST_IDLE` (ready high), `ST_RD_ACCESS` (read strobes low for the read wait), `ST_TURN` (all strobes high, bus released), `ST_WR_SETUP` (select low, data driven, write strobe high), `ST_WR_PULSE` (write strobe low), `ST_WR_HOLD` (write strobe high, data still driven). Transitions: IDLE→RD_ACCESS on an accepted read; IDLE→WR_SETUP on an accepted write when the previous access was not a read; IDLE→TURN on an accepted write after a read; TURN→WR_SETUP when the turnaround count ends; RD_ACCESS→IDLE when the read wait ends; WR_SETUP→WR_PULSE after one cycle; WR_PULSE→WR_HOLD when the pulse count ends; WR_HOLD→IDLE after one cycle.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, every strobe (`sram_ce_n`, `sram_oe_n`, `sram_we_n`, both bits of `sram_be_n`) is high, `sram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A read holds `sram_ce_n` and `sram_oe_n` low with `sram_we_n` high for exactly READ_CYC cycles. `sram_dq_oe` stays 0 throughout.
- R3: Read data is sampled on the last read-wait cycle and appears on `rd_data` together with a `rd_valid` pulse of exactly one cycle. `req_ready` is low from the cycle after acceptance until the access ends.
- R4: A write drives `sram_dq_oe` high for WR_PULSE_CYC+2 cycles. These are one setup cycle with `sram_we_n` high, then WR_PULSE_CYC cycles with `sram_we_n` low, then one hold cycle with `sram_we_n` high and data still driven. `sram_ce_n` is low in all of them.
- R5: Mask bit 0 selects bits 7:0 and mask bit 1 selects bits 15:8. During an access, `sram_be_n[i]` equals the inverse of mask bit i. On a read, the lanes whose mask bit is clear return 0 on `rd_data`.
- R6: `sram_dq_oe` is never high while `sram_oe_n` is low.
- R7: When a write follows a read, at least TURN_CYC+1 cycles with `sram_ce_n` high pass between the end of the read strobes and the rise of `sram_dq_oe`.
- R8: `sram_addr` is stable for as long as `sram_ce_n` stays low, and `sram_dq_o` is stable for as long as `sram_dq_oe` stays high. Each write stores the driven word in the enabled lanes only.
- R9: `sram_ce_n` is high in every cycle in which `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane mask, bit i enables byte i |
| rd_data | output | 16 | Read data, disabled lanes zero |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_be_n | output | 2 | Byte lane enables, active low, bit 0 = low byte |
| sram_dq_o | output | 16 | Data to drive onto the shared bus |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | 16 | Data sampled from the shared bus |

## Verification
The assertions assume that the bus side offers a request only through the valid/ready handshake. They also assume that reset is held for at least one clock edge before the first request. The bench's driver raises `req_valid` only when it has seen `req_ready` high, and it drops the request right after the accepting edge. The memory model in the bench delays valid read data until the third cycle of read strobes, so a shortened read wait would return a poison word. It stores write data only on the rising edge of the write strobe, which exercises the hold and stability rules. The sequences mix full-word and single-lane writes and reads at the first and last addresses, back-to-back reads and read-then-write pairs.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctrl_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [LANES-1:0]  in_mask,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_wdata,
    output logic [LANES-1:0]  q_mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_addr  <= '0;
            q_wdata <= '0;
            q_mask  <= '0;
        end else if (capture) begin
            q_addr  <= in_addr;
            q_wdata <= in_wdata;
            q_mask  <= in_mask;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_data[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rd_data[g*LANE_W +: LANE_W] <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
        end
    end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int DATA_W       = 16,
    parameter int CLK_NS       = 5,
    parameter int READ_CYC     = 3,
    parameter int WR_PULSE_CYC = 3,
    parameter int TURN_CYC     = 1,
    parameter int T_ACC_NS     = 15,
    parameter int T_RCYC_NS    = 15,
    parameter int T_WPW_NS     = 12,
    parameter int T_AWE_NS     = 12,
    parameter int T_DSU_NS     = 8,
    parameter int T_WCYC_NS    = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W/8-1:0] sram_be_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);
    localparam int LANES   = DATA_W / 8;
    localparam int MAX_CYC = max3(READ_CYC, WR_PULSE_CYC, TURN_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    // Elaboration checks: each phase covers its nanosecond minimum.
    if (READ_CYC < 1 || WR_PULSE_CYC < 1 || TURN_CYC < 1) begin : g_bad_min
        $error("phase counts must be at least one cycle");
    end
    if (READ_CYC * CLK_NS < T_ACC_NS || READ_CYC * CLK_NS < T_RCYC_NS) begin : g_bad_rd
        $error("read wait shorter than access or read cycle time");
    end
    if (WR_PULSE_CYC * CLK_NS < T_WPW_NS) begin : g_bad_pw
        $error("write pulse shorter than its minimum width");
    end
    if ((WR_PULSE_CYC + 1) * CLK_NS < T_AWE_NS || (WR_PULSE_CYC + 1) * CLK_NS < T_DSU_NS) begin : g_bad_su
        $error("address or data setup to write end too short");
    end
    if ((WR_PULSE_CYC + 2) * CLK_NS < T_WCYC_NS) begin : g_bad_wc
        $error("write cycle shorter than its minimum");
    end

    ctrl_state_e       state, state_nx;
    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_last;
    logic              after_read;
    logic              rd_capture;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic [LANES-1:0]  q_mask;

    assign accept     = req_valid && (state == ST_IDLE);
    assign rd_capture = (state == ST_RD_ACCESS) && tmr_last;

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_latch (
        .clk      (clk),
        .rst      (rst),
        .capture  (accept),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_mask  (req_mask),
        .q_addr   (q_addr),
        .q_wdata  (q_wdata),
        .q_mask   (q_mask)
    );

    sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) i_rdcap (
        .clk      (clk),
        .rst      (rst),
        .capture  (rd_capture),
        .lane_en  (q_mask),
        .dq_in    (sram_dq_i),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Remembers that the last access drove the bus from the memory side
    always_ff @(posedge clk) begin
        if (rst) begin
            after_read <= 1'b0;
        end else if (rd_capture) begin
            after_read <= 1'b1;
        end else if (state == ST_WR_SETUP) begin
            after_read <= 1'b0;
        end
    end

    // Next state and phase timer loading
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write) begin
                        state_nx = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(READ_CYC - 1);
                    end else if (after_read) begin
                        state_nx = ST_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(TURN_CYC - 1);
                    end else begin
                        state_nx = ST_WR_SETUP;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_last) state_nx = ST_IDLE;
            end
            ST_TURN: begin
                if (tmr_last) state_nx = ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
                state_nx = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_PULSE_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_last) state_nx = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Strobe and bus decode
    always_comb begin
        req_ready  = 1'b0;
        sram_ce_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_be_n  = '1;
        sram_dq_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_RD_ACCESS: begin
                sram_ce_n = 1'b0;
                sram_oe_n = 1'b0;
                sram_be_n = ~q_mask;
            end
            ST_TURN: begin
                sram_ce_n = 1'b1;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                sram_ce_n  = 1'b0;
                sram_be_n  = ~q_mask;
                sram_dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                sram_ce_n  = 1'b0;
                sram_we_n  = 1'b0;
                sram_be_n  = ~q_mask;
                sram_dq_oe = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    assign sram_addr = q_addr;
    assign sram_dq_o = q_wdata;
endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_o
);
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready));

    p_read_strobes_r2: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n && !sram_dq_oe));

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    p_valid_after_read_r3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!sram_oe_n));

    p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_write_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_dq_oe));

    p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    p_data_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

    p_idle_deselect_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> sram_ce_n);
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe),
    .sram_addr  (sram_addr),
    .sram_dq_o  (sram_dq_o)
);

// File: tb/test_sram_port_ctrl.sv
`timescale 1ns/1ps
module test_sram_port_ctrl;
    localparam int RD_N   = 3;
    localparam int WR_N   = 3;
    localparam int TURN_N = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_o;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_i = 16'hDEAD;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    sram_port_ctrl i_sram_port_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_be_n(sram_be_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: data valid only from the third cycle of read strobes
    logic [15:0] dev_mem [int];
    int          rd_age = 0;
    always @(negedge clk) begin
        logic [15:0] w;
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            rd_age++;
            w = dev_mem.exists(int'(sram_addr)) ? dev_mem[int'(sram_addr)] : 16'h0;
            if (rd_age >= 3) begin
                sram_dq_i[7:0]  = sram_be_n[0] ? 8'hA5 : w[7:0];
                sram_dq_i[15:8] = sram_be_n[1] ? 8'hA5 : w[15:8];
            end else begin
                sram_dq_i = 16'hDEAD;
            end
        end else begin
            rd_age    = 0;
            sram_dq_i = 16'hDEAD;
        end
    end

    always @(posedge sram_we_n) begin
        if (sram_ce_n === 1'b0 && sram_dq_oe === 1'b1) begin
            logic [15:0] w;
            w = dev_mem.exists(int'(sram_addr)) ? dev_mem[int'(sram_addr)] : 16'h0;
            if (!sram_be_n[0]) w[7:0]  = sram_dq_o[7:0];
            if (!sram_be_n[1]) w[15:8] = sram_dq_o[15:8];
            dev_mem[int'(sram_addr)] = w;
        end
    end

    // Scoreboard
    logic [15:0] shadow [int];
    logic [17:0] rd_q [$];
    logic [1:0]  wr_q [$];

    task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] w;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        if (m[0]) w[7:0]  = d[7:0];
        if (m[1]) w[15:8] = d[15:8];
        shadow[int'(a)] = w;
        wr_q.push_back(m);
        issue(1'b1, a, d, m);
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] m);
        logic [15:0] w;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        if (!m[0]) w[7:0]  = 8'h00;
        if (!m[1]) w[15:8] = 8'h00;
        rd_q.push_back({m, w});
        issue(1'b0, a, 16'h0, m);
    endtask

    // Monitor
    int   rd_cnt = 0, we_cnt = 0, oe_cnt = 0, gap = 0;
    logic [1:0] rd_lanes = '1, wr_lanes = '1;
    bit   prev_oe = 1'b0, after_rd = 1'b0;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (sram_dq_oe && !sram_oe_n) check(1'b0, "R6 contention", {31'h0, sram_oe_n}, 32'h1);
            if (req_ready) check(sram_ce_n, "R9 idle deselect", {31'h0, sram_ce_n}, 32'h1);
            if (!sram_oe_n) begin
                rd_cnt++;
                rd_lanes = sram_be_n;
            end
            if (rd_valid) begin
                logic [17:0] e;
                if (rd_q.size() == 0) begin
                    check(1'b0, "R3 unexpected rd_valid", 32'h1, 32'h0);
                end else begin
                    e = rd_q.pop_front();
                    check(rd_data == e[15:0], "R3/R5/R8 read data", {16'h0, rd_data}, {16'h0, e[15:0]});
                    check(rd_lanes == ~e[17:16], "R5 read lanes", {30'h0, rd_lanes}, {30'h0, ~e[17:16]});
                end
                check(rd_cnt == RD_N, "R2 read strobe cycles", rd_cnt, RD_N);
                rd_cnt   = 0;
                after_rd = 1'b1;
            end
            if (sram_dq_oe && !prev_oe) begin
                if (after_rd) check(gap >= TURN_N + 1, "R7 turnaround gap", gap, TURN_N + 1);
                after_rd = 1'b0;
            end
            if (sram_dq_oe) begin
                oe_cnt++;
                if (!sram_we_n) begin
                    we_cnt++;
                    wr_lanes = sram_be_n;
                end
            end
            if (!sram_dq_oe && prev_oe) begin
                logic [1:0] m;
                m = (wr_q.size() != 0) ? wr_q.pop_front() : 2'b00;
                check(we_cnt == WR_N, "R4 write pulse cycles", we_cnt, WR_N);
                check(oe_cnt == WR_N + 2, "R4 drive cycles", oe_cnt, WR_N + 2);
                check(wr_lanes == ~m, "R5 write lanes", {30'h0, wr_lanes}, {30'h0, ~m});
                we_cnt = 0;
                oe_cnt = 0;
            end
            if (sram_ce_n) gap++;
            else gap = 0;
            prev_oe = sram_dq_oe;
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        check(sram_ce_n && sram_oe_n && sram_we_n && (sram_be_n == 2'b11),
              "R1 strobes in reset", {27'h0, sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}, 32'h1F);
        check(!sram_dq_oe && !rd_valid && req_ready, "R1 bus and handshake in reset",
              {29'h0, sram_dq_oe, rd_valid, req_ready}, 32'h1);
        rst = 1'b0;
        @(negedge clk);
        check(sram_ce_n && !sram_dq_oe && req_ready, "R1 first cycle after reset",
              {29'h0, sram_ce_n, sram_dq_oe, req_ready}, 32'h5);

        // Full words, then lane reads (R5)
        do_write(18'h00010, 16'h1234, 2'b11);
        do_write(18'h00020, 16'hABCD, 2'b11);
        do_read (18'h00010, 2'b11);
        do_read (18'h00020, 2'b01);
        do_read (18'h00020, 2'b10);
        // Partial writes right after reads (R7, R8)
        do_write(18'h00010, 16'h5566, 2'b01);
        do_read (18'h00010, 2'b11);
        do_write(18'h00010, 16'h77FF, 2'b10);
        do_read (18'h00010, 2'b11);
        // A write with no lanes stores nothing
        do_write(18'h00020, 16'hFFFF, 2'b00);
        do_read (18'h00020, 2'b11);
        // Address boundaries
        do_write(18'h00000, 16'h0F0F, 2'b11);
        do_write(18'h3FFFF, 16'hF00D, 2'b11);
        do_read (18'h3FFFF, 2'b11);
        do_read (18'h00000, 2'b11);

        // R3: ready is low while an access runs
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00010; req_mask = 2'b11;
        rd_q.push_back({2'b11, shadow[32'h10]});
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R3 ready low after accept", {31'h0, req_ready}, 32'h0);

        // Mixed patterns
        for (int i = 0; i < 24; i++) begin
            logic [17:0] a;
            a = 18'((i * 18'h0A3B5) ^ 18'h15555);
            do_write(a, 16'((i * 16'h3D1) ^ 16'hC35A), 2'((i % 3) + 1));
            do_read(a, 2'b11);
            if (i % 4 == 0) do_read(a, 2'((i % 2) + 1));
        end

        repeat (20) @(negedge clk);
        check(rd_q.size() == 0, "R3 all reads returned", rd_q.size(), 0);
        check(wr_q.size() == 0, "R4 all writes ended", wr_q.size(), 0);
        report();
    end
endmodule